// File: doc/BRIEF.md
# Woven ROM Core Selection Sequencer

This block controls a read-only store in which every data bit is fixed by how a sense wire is routed: either through a magnetic core or around it. Each core carries many wires, so one core holds several whole words. A read takes a linear word address and splits it into a module, a plane, a core and a strand. The block then runs a timed sequence. It raises inhibit lines that block every core except the addressed one, and it pulses the set line shared by the wanted plane's pair while it holds back the sibling plane with that plane's reset line. It then resets only the wanted plane, so the flipped core induces its woven bits. Finally it delivers the selected strand as a 16-bit word. The word has 15 data bits and one odd parity bit.

The woven content comes from a behavioural rope model inside the block. The content is a computed pattern set by parameters, so a testbench fixes the content when it chooses the parameter values, including one deliberately miswoven word. An abort request during a read sends the block through a clear phase, which returns any core left set to its rest state. A read at an address beyond the last word ends early with an error flag and no data.

Top module: `rope_rom_seq`

## Requirements
- R1: The address splits with the strand index varying fastest: strand = addr mod S, core = (addr / S) mod C, plane = (addr / (S*C)) mod 4, module = addr / (4*S*C), where S is the strand count and C = 2^CORE_BITS. During the set and sense phases `module_sel` is one-hot at the module index.
- R2: During the set phase, inhibit bit 2k equals core-address bit k and bit 2k+1 equals its complement, for k below CORE_BITS. Bit 2*CORE_BITS equals the XOR of the core address bits and the bit above it equals the complement. Outside the set phase every inhibit line is low.
- R3: In the set phase a core j is hit by line 2k when bit k of j is 0, by line 2k+1 when bit k of j is 1, and by the two parity lines in the same way against the parity of j. The addressed core receives no hit, and every other core receives at least two.
- R4: During the set phase exactly one set line is high: bit 0 for planes 0 and 1, bit 1 for planes 2 and 3. The only reset line that is high is that of the sibling plane (plane XOR 1).
- R5: During the sense phase only `reset_line[plane]` is high, the set lines are low, and `strand_sel` is one-hot at the strand index.
- R6: A start accepted while idle keeps `busy` high for DEC_CYC+SET_CYC+RST_CYC+1 cycles. The decode phase lasts DEC_CYC cycles, the set phase SET_CYC cycles and the sense phase RST_CYC cycles. `data_valid` is high in the final cycle only. A start received while busy is ignored.
- R7: With `data_valid` high, `rdata[14:0]` equals ((a*WEAVE_MUL + WEAVE_ADD) XOR (a >> 5)) mod 2^15. `rdata[15]` makes the number of ones in the word odd, and it is inverted for the address FAULT_LIN.
- R8: `parity_err` is high together with `data_valid` exactly when the delivered word has an even number of ones.
- R9: An address at or beyond the word count keeps `busy` high for DEC_CYC+1 cycles and raises `range_err` in the last of them. It drives no set, reset or inhibit line, never raises `data_valid`, and leaves `rdata` at 0.
- R10: An `abort` seen during the decode, set or sense phase moves the block into a clear phase of CLR_CYC cycles with `clear_line` high. `data_valid` stays low, `busy` falls afterwards, and the next read returns a correct word.
- R11: During reset and afterwards, until a start arrives, `busy`, every drive line, `data_valid`, `range_err` and `parity_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a read of `addr` (taken only when idle) |
| addr | input | ADDR_W | Linear word address |
| abort | input | 1 | Abandon the read in progress |
| busy | output | 1 | A read or a clear is in progress |
| module_sel | output | N_MOD | One-hot module drive |
| strand_sel | output | N_STRAND | One-hot strand drive in the sense phase |
| inhibit | output | 2*(CORE_BITS+1) | Address and parity inhibit lines, true and complement |
| set_line | output | 2 | Set drive for the plane pairs {0,1} and {2,3} |
| reset_line | output | 4 | Per-plane reset drive |
| clear_line | output | 1 | Clear drive through all cores |
| data_valid | output | 1 | `rdata` holds the word read |
| rdata | output | 16 | Parity bit in bit 15, data in bits 14:0 |
| parity_err | output | 1 | Delivered word has even parity |
| range_err | output | 1 | Read address out of range |

## Verification
A wrong internal index or phase shows up on the line ports within the same read. A miscounted phase moves the edges of `set_line`, `reset_line` and `strand_sel` by whole cycles. A bad field split lights the wrong `module_sel`, inhibit or strand bit. A broken blocking scheme leaves a core set in a sibling plane or in the same plane. That stray core is ORed into the next word sensed from that plane, so the error appears as a corrupt `rdata` or as a `parity_err` on a later read rather than on the faulty one.

// File: rtl/rope_pkg.sv
package rope_pkg;

  localparam int PLANES = 4;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DECODE,
    PH_SET,
    PH_SENSE,
    PH_DONE,
    PH_CLEAR
  } phase_e;

  // index width for a count of n items, never below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // woven content of one linear word: 15 data bits, odd parity on top,
  // parity deliberately wrong at the fault address
  function automatic logic [WORD_W-1:0] weave_word(input logic [31:0] lin,
                                                   input logic [31:0] mul,
                                                   input logic [31:0] add,
                                                   input logic [31:0] fault);
    logic [31:0] mix;
    logic [14:0] d;
    logic        p;
    mix = (lin * mul + add) ^ (lin >> 5);
    d   = mix[14:0];
    p   = ~(^d);
    if (lin == fault) p = ~p;
    return {p, d};
  endfunction

  function automatic logic odd_ones(input logic [WORD_W-1:0] w);
    return ^w;
  endfunction

endpackage

// File: rtl/rope_addr_split.sv
module rope_addr_split
  import rope_pkg::*;
#(
  parameter int N_MOD     = 6,
  parameter int CORE_BITS = 7,
  parameter int N_STRAND  = 12,
  parameter int ADDR_W    = 16,
  localparam int MOD_W    = idx_w(N_MOD),
  localparam int STR_W    = idx_w(N_STRAND)
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [MOD_W-1:0]     mod_idx,
  output logic [1:0]           plane_idx,
  output logic [CORE_BITS-1:0] core_idx,
  output logic [STR_W-1:0]     strand_idx,
  output logic                 in_range
);

  localparam int N_CORE    = 1 << CORE_BITS;
  localparam int PER_PLANE = N_CORE * N_STRAND;
  localparam int PER_MOD   = PER_PLANE * PLANES;
  localparam int TOTAL     = PER_MOD * N_MOD;

  logic [31:0] a_w, rem_mod, rem_plane;

  always_comb begin
    a_w        = 32'(addr);
    in_range   = (a_w < 32'(TOTAL));
    rem_mod    = a_w % 32'(PER_MOD);
    rem_plane  = rem_mod % 32'(PER_PLANE);
    mod_idx    = MOD_W'(a_w / 32'(PER_MOD));
    plane_idx  = 2'(rem_mod / 32'(PER_PLANE));
    core_idx   = CORE_BITS'(rem_plane / 32'(N_STRAND));
    strand_idx = STR_W'(rem_plane % 32'(N_STRAND));
  end

endmodule

// File: rtl/rope_line_drv.sv
module rope_line_drv
  import rope_pkg::*;
#(
  parameter int N_MOD     = 6,
  parameter int CORE_BITS = 7,
  parameter int N_STRAND  = 12,
  localparam int MOD_W    = idx_w(N_MOD),
  localparam int STR_W    = idx_w(N_STRAND),
  localparam int INH_W    = 2 * (CORE_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  phase_e               phase,
  input  logic [MOD_W-1:0]     mod_idx,
  input  logic [1:0]           plane_idx,
  input  logic [CORE_BITS-1:0] core_idx,
  input  logic [STR_W-1:0]     strand_idx,
  output logic [INH_W-1:0]     inhibit,
  output logic [1:0]           set_line,
  output logic [PLANES-1:0]    reset_line,
  output logic                 clear_line,
  output logic [N_MOD-1:0]     module_sel,
  output logic [N_STRAND-1:0]  strand_sel
);

  logic in_set, in_sense, in_clear, addr_par;

  assign in_set   = (phase == PH_SET);
  assign in_sense = (phase == PH_SENSE);
  assign in_clear = (phase == PH_CLEAR);
  assign addr_par = ^core_idx;

  for (genvar k = 0; k < CORE_BITS; k++) begin : g_inh
    assign inhibit[2*k]   = in_set &  core_idx[k];
    assign inhibit[2*k+1] = in_set & ~core_idx[k];
  end
  assign inhibit[2*CORE_BITS]   = in_set &  addr_par;
  assign inhibit[2*CORE_BITS+1] = in_set & ~addr_par;

  // shared set per pair, sibling held back by its own reset
  assign set_line   = in_set ? (2'b01 << plane_idx[1]) : 2'b00;
  assign reset_line = in_set   ? (4'b0001 << {plane_idx[1], ~plane_idx[0]}) :
                      in_sense ? (4'b0001 << plane_idx) : 4'b0000;
  assign clear_line = in_clear;
  assign module_sel = (in_set | in_sense | in_clear) ? (N_MOD'(1) << mod_idx) : '0;
  assign strand_sel = in_sense ? (N_STRAND'(1) << strand_idx) : '0;

  // R2
  inh_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_line) |-> ($countones(inhibit) == CORE_BITS + 1));

  // R2
  inh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_line == 2'b00) |-> (inhibit == '0));

  // R4
  pair_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_line) |-> ($countones(set_line) == 1 && $countones(reset_line) == 1 &&
                     set_line[1] == (reset_line[2] | reset_line[3])));

  // R5
  strand_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|strand_sel) |-> ($onehot(strand_sel) && set_line == 2'b00 && $onehot(reset_line)));

endmodule

// File: rtl/rope_weave_model.sv
module rope_weave_model
  import rope_pkg::*;
#(
  parameter int          N_MOD     = 6,
  parameter int          CORE_BITS = 7,
  parameter int          N_STRAND  = 12,
  parameter logic [31:0] WEAVE_MUL = 32'h0000_9E37,
  parameter logic [31:0] WEAVE_ADD = 32'h0000_1234,
  parameter logic [31:0] FAULT_LIN = 32'hFFFF_FFFF,
  localparam int MOD_W   = idx_w(N_MOD),
  localparam int STR_W   = idx_w(N_STRAND),
  localparam int INH_W   = 2 * (CORE_BITS + 1),
  localparam int N_CORE  = 1 << CORE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [INH_W-1:0]     inhibit,
  input  logic [1:0]           set_line,
  input  logic [PLANES-1:0]    reset_line,
  input  logic                 clear_line,
  input  logic [MOD_W-1:0]     mod_idx,
  input  logic [STR_W-1:0]     strand_idx,
  output logic                 sense_hit,
  output logic [WORD_W-1:0]    sense_word,
  output logic                 any_set
);

  logic [N_CORE-1:0]                flip_v;
  logic [N_CORE-1:0]                weak_v;
  logic [CORE_BITS-1:0]             flip_idx;
  logic [PLANES-1:0]                held;
  logic [PLANES-1:0][WORD_W-1:0]    held_word;

  // each core counts the inhibit lines threaded through it
  for (genvar j = 0; j < N_CORE; j++) begin : g_core
    localparam logic [CORE_BITS-1:0] JV = CORE_BITS'(j);
    localparam logic                 JP = ^JV;
    logic [CORE_BITS:0] hits;
    for (genvar k = 0; k < CORE_BITS; k++) begin : g_bit
      assign hits[k] = JV[k] ? inhibit[2*k+1] : inhibit[2*k];
    end
    assign hits[CORE_BITS] = JP ? inhibit[2*CORE_BITS+1] : inhibit[2*CORE_BITS];
    assign flip_v[j] = (|set_line) && (hits == '0);
    assign weak_v[j] = (hits != '0) && ((hits & (hits - 1'b1)) == '0);
  end

  always_comb begin
    flip_idx = '0;
    for (int j = 0; j < N_CORE; j++) begin
      if (flip_v[j]) flip_idx = CORE_BITS'(j);
    end
  end

  function automatic logic [31:0] lin_of(input int p);
    return ((32'(mod_idx) * 32'(PLANES) + 32'(p)) * 32'(N_CORE) + 32'(flip_idx))
           * 32'(N_STRAND) + 32'(strand_idx);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= '0;
      held_word <= '0;
    end else if (clear_line) begin
      held      <= '0;
      held_word <= '0;
    end else begin
      for (int p = 0; p < PLANES; p++) begin
        if (set_line[p/2] && !reset_line[p] && (|flip_v)) begin
          held[p]      <= 1'b1;
          held_word[p] <= held_word[p] |
                          weave_word(lin_of(p), WEAVE_MUL, WEAVE_ADD, FAULT_LIN);
        end else if (reset_line[p]) begin
          held[p]      <= 1'b0;
          held_word[p] <= '0;
        end
      end
    end
  end

  always_comb begin
    sense_hit  = 1'b0;
    sense_word = '0;
    for (int p = 0; p < PLANES; p++) begin
      if (reset_line[p] && !set_line[p/2] && held[p]) begin
        sense_hit  = 1'b1;
        sense_word = held_word[p];
      end
    end
  end

  assign any_set = |held;

  // R3
  weak_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_line) |-> (weak_v == '0));

  // R3
  single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_line) |-> ($countones(flip_v) == 1));

  // R4
  held_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(held));

endmodule

// File: rtl/rope_rom_seq.sv
module rope_rom_seq
  import rope_pkg::*;
#(
  parameter int          N_MOD     = 6,
  parameter int          CORE_BITS = 7,
  parameter int          N_STRAND  = 12,
  parameter int          ADDR_W    = 16,
  parameter int          DEC_CYC   = 1,
  parameter int          SET_CYC   = 2,
  parameter int          RST_CYC   = 2,
  parameter int          CLR_CYC   = 2,
  parameter logic [31:0] WEAVE_MUL = 32'h0000_9E37,
  parameter logic [31:0] WEAVE_ADD = 32'h0000_1234,
  parameter logic [31:0] FAULT_LIN = 32'hFFFF_FFFF,
  localparam int INH_W = 2 * (CORE_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  abort,
  output logic                  busy,
  output logic [N_MOD-1:0]      module_sel,
  output logic [N_STRAND-1:0]   strand_sel,
  output logic [INH_W-1:0]      inhibit,
  output logic [1:0]            set_line,
  output logic [3:0]            reset_line,
  output logic                  clear_line,
  output logic                  data_valid,
  output logic [15:0]           rdata,
  output logic                  parity_err,
  output logic                  range_err
);

  localparam int MOD_W = idx_w(N_MOD);
  localparam int STR_W = idx_w(N_STRAND);
  localparam int MAXC  = max4(DEC_CYC, SET_CYC, RST_CYC, CLR_CYC);
  localparam int CNT_W = idx_w(MAXC);

  phase_e               ph;
  logic [CNT_W-1:0]     cnt;
  logic [MOD_W-1:0]     a_mod, r_mod;
  logic [1:0]           a_plane, r_plane;
  logic [CORE_BITS-1:0] a_core, r_core;
  logic [STR_W-1:0]     a_strand, r_strand;
  logic                 a_range, r_range;
  logic [WORD_W-1:0]    r_word;
  logic                 sense_hit, any_set;
  logic [WORD_W-1:0]    sense_word;

  rope_addr_split #(
    .N_MOD(N_MOD), .CORE_BITS(CORE_BITS), .N_STRAND(N_STRAND), .ADDR_W(ADDR_W)
  ) u_split (
    .addr(addr), .mod_idx(a_mod), .plane_idx(a_plane), .core_idx(a_core),
    .strand_idx(a_strand), .in_range(a_range)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      r_mod    <= '0;
      r_plane  <= '0;
      r_core   <= '0;
      r_strand <= '0;
      r_range  <= 1'b0;
      r_word   <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          r_mod    <= a_mod;
          r_plane  <= a_plane;
          r_core   <= a_core;
          r_strand <= a_strand;
          r_range  <= a_range;
          r_word   <= '0;
          cnt      <= '0;
          ph       <= PH_DECODE;
        end
        PH_DECODE: begin
          if (abort) begin
            cnt <= '0;
            ph  <= PH_CLEAR;
          end else if (cnt == CNT_W'(DEC_CYC - 1)) begin
            cnt <= '0;
            ph  <= r_range ? PH_SET : PH_DONE;
          end else cnt <= cnt + 1'b1;
        end
        PH_SET: begin
          if (abort) begin
            cnt <= '0;
            ph  <= PH_CLEAR;
          end else if (cnt == CNT_W'(SET_CYC - 1)) begin
            cnt <= '0;
            ph  <= PH_SENSE;
          end else cnt <= cnt + 1'b1;
        end
        PH_SENSE: begin
          if (sense_hit) r_word <= sense_word;
          if (abort) begin
            cnt <= '0;
            ph  <= PH_CLEAR;
          end else if (cnt == CNT_W'(RST_CYC - 1)) begin
            cnt <= '0;
            ph  <= PH_DONE;
          end else cnt <= cnt + 1'b1;
        end
        PH_DONE: ph <= PH_IDLE;
        PH_CLEAR: begin
          if (cnt == CNT_W'(CLR_CYC - 1)) begin
            cnt <= '0;
            ph  <= PH_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  rope_line_drv #(
    .N_MOD(N_MOD), .CORE_BITS(CORE_BITS), .N_STRAND(N_STRAND)
  ) u_drv (
    .clk(clk), .rst_n(rst_n), .phase(ph), .mod_idx(r_mod), .plane_idx(r_plane),
    .core_idx(r_core), .strand_idx(r_strand), .inhibit(inhibit), .set_line(set_line),
    .reset_line(reset_line), .clear_line(clear_line), .module_sel(module_sel),
    .strand_sel(strand_sel)
  );

  rope_weave_model #(
    .N_MOD(N_MOD), .CORE_BITS(CORE_BITS), .N_STRAND(N_STRAND),
    .WEAVE_MUL(WEAVE_MUL), .WEAVE_ADD(WEAVE_ADD), .FAULT_LIN(FAULT_LIN)
  ) u_rope (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .set_line(set_line),
    .reset_line(reset_line), .clear_line(clear_line), .mod_idx(r_mod),
    .strand_idx(r_strand), .sense_hit(sense_hit), .sense_word(sense_word),
    .any_set(any_set)
  );

  assign busy       = (ph != PH_IDLE);
  assign data_valid = (ph == PH_DONE) && r_range;
  assign range_err  = (ph == PH_DONE) && !r_range;
  assign rdata      = data_valid ? r_word : '0;
  assign parity_err = data_valid && !odd_ones(r_word);

  // R5
  sense_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sense_hit |-> (ph == PH_SENSE));

  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid || range_err) |=> (!busy && !data_valid));

  // R8
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> data_valid);

  // R9
  range_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> (!data_valid && rdata == '0 && set_line == 2'b00));

  // R10
  idle_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !any_set);

  // R10
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_line |-> (!data_valid && set_line == 2'b00 && reset_line == 4'b0000));

endmodule

// File: tb/rope_rom_seq_tb.sv
module rope_rom_seq_tb;

  localparam int NM = 2, CB = 3, NS = 3, AW = 8;
  localparam int DC = 1, SC = 2, RC = 2, CC = 2;
  localparam int NC = 1 << CB;
  localparam int PLANE_WORDS = NC * NS;
  localparam int MOD_WORDS = PLANE_WORDS * 4;
  localparam int TOT = MOD_WORDS * NM;
  localparam int MUL = 'h9E37, ADD = 'h1234, FLT = 37;
  localparam int INW = 2 * (CB + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic busy, clear_line, data_valid, parity_err, range_err;
  logic [NM-1:0] module_sel;
  logic [NS-1:0] strand_sel;
  logic [INW-1:0] inhibit;
  logic [1:0] set_line;
  logic [3:0] reset_line;
  logic [15:0] rdata;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rope_rom_seq #(
    .N_MOD(NM), .CORE_BITS(CB), .N_STRAND(NS), .ADDR_W(AW),
    .DEC_CYC(DC), .SET_CYC(SC), .RST_CYC(RC), .CLR_CYC(CC),
    .WEAVE_MUL(32'(MUL)), .WEAVE_ADD(32'(ADD)), .FAULT_LIN(32'(FLT))
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr_i), .abort(abort),
    .busy(busy), .module_sel(module_sel), .strand_sel(strand_sel), .inhibit(inhibit),
    .set_line(set_line), .reset_line(reset_line), .clear_line(clear_line),
    .data_valid(data_valid), .rdata(rdata), .parity_err(parity_err), .range_err(range_err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_word(input int a);
    int d, ones;
    d = ((a * MUL + ADD) ^ (a >> 5)) & 'h7FFF;
    ones = 0;
    for (int b = 0; b < 15; b++) ones += (d >> b) & 1;
    if (ones % 2 == 0) d = d | 'h8000;
    if (a == FLT) d = d ^ 'h8000;
    return d;
  endfunction

  task automatic run_read(input int a, input bit poke);
    int m, p, c, s, L, par, ew;
    bit inr;
    inr = (a < TOT);
    m = a / MOD_WORDS;
    p = (a % MOD_WORDS) / PLANE_WORDS;
    c = (a % PLANE_WORDS) / NS;
    s = a % NS;
    L = inr ? DC + SC + RC + 1 : DC + 1;
    par = 0;
    for (int b = 0; b < CB; b++) par ^= (c >> b) & 1;
    ew = exp_word(a);
    @(negedge clk); start = 1'b1; addr_i = AW'(a);
    @(negedge clk); start = 1'b0;
    for (int k = 1; k <= L + 1; k++) begin
      bit st, se;
      int e_inh, e_set, e_rst, e_mod, e_str;
      if (k > 1) @(negedge clk);
      if (poke && k == 2) begin start = 1'b1; addr_i = AW'((a + 1) % TOT); end
      if (poke && k == 3) start = 1'b0;
      st = inr && k > DC && k <= DC + SC;
      se = inr && k > DC + SC && k <= DC + SC + RC;
      e_inh = 0;
      if (st) begin
        for (int b = 0; b < CB; b++)
          e_inh |= ((c >> b) & 1) ? (1 << (2 * b)) : (1 << (2 * b + 1));
        e_inh |= par ? (1 << (2 * CB)) : (1 << (2 * CB + 1));
      end
      e_set = st ? (1 << (p / 2)) : 0;
      e_rst = st ? (1 << (p ^ 1)) : (se ? (1 << p) : 0);
      e_mod = (st || se) ? (1 << m) : 0;
      e_str = se ? (1 << s) : 0;
      chk(inhibit == INW'(e_inh), "R2 inhibit lines", inhibit, e_inh);
      chk(set_line == 2'(e_set), "R4 set lines", set_line, e_set);
      chk(reset_line == 4'(e_rst), "R4/R5 reset lines", reset_line, e_rst);
      chk(module_sel == NM'(e_mod), "R1 module select", module_sel, e_mod);
      chk(strand_sel == NS'(e_str), "R5 strand select", strand_sel, e_str);
      chk(busy == (k <= L), "R6 busy window", busy, k <= L);
      chk(data_valid == (inr && k == L), "R6 data_valid timing", data_valid, inr && k == L);
      chk(range_err == (!inr && k == L), "R9 range_err timing", range_err, !inr && k == L);
      chk(clear_line == 1'b0, "R10 clear idle in read", clear_line, 0);
      if (st) begin
        // R3: count hits on every core from the observed lines
        for (int j = 0; j < NC; j++) begin
          int h, jp;
          h = 0; jp = 0;
          for (int b = 0; b < CB; b++) begin
            jp ^= (j >> b) & 1;
            h += ((j >> b) & 1) ? int'(inhibit[2*b+1]) : int'(inhibit[2*b]);
          end
          h += jp ? int'(inhibit[2*CB+1]) : int'(inhibit[2*CB]);
          chk((j == c) ? (h == 0) : (h >= 2), "R3 core hit count", h, (j == c) ? 0 : 2);
        end
      end
      if (k == L) begin
        if (inr) begin
          chk(rdata == 16'(ew), "R7 woven word", rdata, ew);
          chk(parity_err == (a == FLT), "R8 parity flag", parity_err, a == FLT);
        end else begin
          chk(rdata == 16'h0, "R9 no data", rdata, 0);
        end
      end
    end
    if (poke) begin
      @(negedge clk);
      chk(!busy && !data_valid, "R6 start ignored while busy", busy, 0);
    end
  endtask

  task automatic abort_read(input int a, input int ak);
    @(negedge clk); start = 1'b1; addr_i = AW'(a);
    @(negedge clk); start = 1'b0;
    for (int k = 1; k <= ak + CC + 1; k++) begin
      if (k > 1) @(negedge clk);
      abort = (k == ak);
      if (k > ak) begin
        chk(clear_line == (k <= ak + CC), "R10 clear_line window", clear_line, k <= ak + CC);
        chk(busy == (k <= ak + CC), "R10 busy after abort", busy, k <= ak + CC);
        chk(data_valid == 1'b0, "R10 no data after abort", data_valid, 0);
      end
    end
    abort = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !data_valid && !range_err, "R11 status in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !data_valid && !range_err && !parity_err, "R11 status after reset", busy, 0);
    chk(inhibit == '0 && set_line == '0 && reset_line == '0 && !clear_line &&
        module_sel == '0 && strand_sel == '0, "R11 lines after reset", inhibit, 0);
    for (int a = 0; a < TOT; a++) run_read(a, 1'b0);
    run_read(TOT, 1'b0);
    run_read(TOT + 8, 1'b0);
    run_read(255, 1'b0);
    run_read(10, 1'b1);
    run_read(100, 1'b1);
    abort_read(3, DC + 1);
    run_read(13, 1'b0);
    abort_read(3, DC + SC + 1);
    run_read(16, 1'b0);
    abort_read(50, DC);
    run_read(50, 1'b0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule